// File: doc/BRIEF.md
# Hysteresis Envelope Comparator with Interrupt

This block watches a stream of unsigned 16-bit envelope samples and turns them into a one-bit level. The level goes high once a sample rises above a programmable threshold. It goes low only after a sample drops below a lower bound, which is the threshold minus a programmable hysteresis value. Samples inside the band between the two bounds leave the level as it was, so a noisy envelope near the threshold does not make the level chatter.

A polarity bit chooses which edge of the level raises an interrupt: the rising edge or the falling edge. The interrupt flag is sticky and stays set until a one-cycle clear pulse arrives.

Two 16-bit words configure the block through a small write/read port. The control word (select 0) holds the polarity in bit 15 and the hysteresis in bits 14..0. The threshold word (select 1) is a full 16-bit value.

Top module: `env_hyst_cmp`

## Requirements
- R1: After reset, level_o and irq_o are 0, and both configuration words read back as 0000h.
- R2: A write with reg_sel=0 stores the control word. Bit 15 is the polarity and bits 14..0 are the hysteresis. Reading with reg_sel=0 returns the word exactly as written.
- R3: A write with reg_sel=1 stores the 16-bit threshold. Reading with reg_sel=1 returns it exactly as written.
- R4: A valid sample strictly greater than the threshold sets level_o. The new value is visible after the clock edge that accepts the sample.
- R5: A valid sample strictly less than (threshold minus hysteresis) clears level_o after that edge.
- R6: A valid sample from (threshold minus hysteresis) up to the threshold, both ends included, leaves level_o unchanged.
- R7: All comparisons are unsigned, and the lower bound saturates at zero. When the hysteresis is at least the threshold, no sample can clear level_o.
- R8: While samp_vld is low, level_o does not change and no edge is detected, whatever the value on samp_data.
- R9: With polarity 0, a 0-to-1 change of level_o sets irq_o at the same edge. With polarity 1, a 1-to-0 change sets it instead. A change in the other direction does not set irq_o.
- R10: irq_o stays set until irq_clr is high at a clock edge. If a qualifying level change happens at that same edge, irq_o stays set.
- R11: Writing any configuration word does not change level_o by itself. The new values apply from the next accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| samp_vld | input | 1 | Marks samp_data as a valid sample this cycle |
| samp_data | input | 16 | Unsigned envelope sample |
| reg_wr | input | 1 | Write strobe for the configuration port |
| reg_sel | input | 1 | Word select: 0 = control, 1 = threshold |
| reg_wdata | input | 16 | Write data |
| irq_clr | input | 1 | One-cycle clear pulse for the interrupt flag |
| reg_rdata | output | 16 | Combinational read of the word chosen by reg_sel |
| level_o | output | 1 | Comparator level |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
Level and interrupt results are due one clock edge after a sample is presented. The bench drives inputs on the falling edge, lets one rising edge pass, then compares against its own model on the next falling edge. A configuration write takes effect at the edge where it is presented, while a sample at that same edge still sees the old values, and the model applies the write after the sample in the same way. Read data is combinational, so reads are checked a short delay after reg_sel is set, with no clock edge in between.

// File: rtl/env_cmp_pkg.sv
package env_cmp_pkg;
  localparam int unsigned SAMPLE_W = 16;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_THR  = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/env_rst_sync.sv
module env_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_comb chain_d[g] = chain_q[g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/env_cfg_regs.sv
module env_cfg_regs
  import env_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = SAMPLE_W,
  localparam int unsigned HYST_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] thr,
  output logic [HYST_W-1:0] hyst,
  output logic              pol
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] thr_q, thr_d;
  logic              ctrl_en, thr_en;

  always_comb begin
    ctrl_en = wr_en && (cfg_sel_e'(sel) == SEL_CTRL);
    thr_en  = wr_en && (cfg_sel_e'(sel) == SEL_THR);
    ctrl_d  = ctrl_en ? wdata : ctrl_q;
    thr_d   = thr_en  ? wdata : thr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      thr_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      thr_q  <= thr_d;
    end
  end

  always_comb begin
    rdata = (cfg_sel_e'(sel) == SEL_THR) ? thr_q : ctrl_q;
    thr   = thr_q;
    hyst  = ctrl_q[HYST_W-1:0];
    pol   = ctrl_q[DATA_W-1];
  end
endmodule

// File: rtl/env_level_core.sv
module env_level_core #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned HYST_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] thr,
  input  logic [HYST_W-1:0] hyst,
  output logic              level,
  output logic              rise,
  output logic              fall
);
  logic [DATA_W:0]   diff;
  logic              borrow;
  logic [DATA_W-1:0] lower;
  logic              above, below;
  logic              level_q, level_d;

  // Lower bound, saturating at zero when hysteresis exceeds the threshold.
  always_comb begin
    diff   = {1'b0, thr} - {2'b00, hyst};
    borrow = diff[DATA_W];
    lower  = borrow ? '0 : diff[DATA_W-1:0];
    above  = sample > thr;
    below  = sample < lower;
  end

  always_comb begin
    level_d = level_q;
    if (vld) begin
      if (above)      level_d = 1'b1;
      else if (below) level_d = 1'b0;
    end
    rise = !level_q &&  level_d;
    fall =  level_q && !level_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end

  assign level = level_q;
endmodule

// File: rtl/env_irq_flag.sv
module env_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic fall,
  input  logic pol,
  input  logic clr,
  output logic irq
);
  logic hit;
  logic irq_q, irq_d;

  always_comb begin
    hit = pol ? fall : rise;
    if (hit)      irq_d = 1'b1;
    else if (clr) irq_d = 1'b0;
    else          irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/env_hyst_cmp.sv
module env_hyst_cmp
  import env_cmp_pkg::*;
#(
  parameter int unsigned DATA_W      = SAMPLE_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned HYST_W     = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_vld,
  input  logic [DATA_W-1:0] samp_data,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              level_o,
  output logic              irq_o
);
  logic              rst_int_n;
  logic [DATA_W-1:0] thr_q;
  logic [HYST_W-1:0] hyst_q;
  logic              pol_q;
  logic              lvl_rise, lvl_fall;

  env_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_int_n)
  );

  env_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata), .thr(thr_q), .hyst(hyst_q),
    .pol(pol_q)
  );

  env_level_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_int_n), .vld(samp_vld), .sample(samp_data),
    .thr(thr_q), .hyst(hyst_q), .level(level_o), .rise(lvl_rise),
    .fall(lvl_fall)
  );

  env_irq_flag u_irq (
    .clk(clk), .rst_n(rst_int_n), .rise(lvl_rise), .fall(lvl_fall),
    .pol(pol_q), .clr(irq_clr), .irq(irq_o)
  );
endmodule

// File: rtl/env_hyst_cmp_chk.sv
module env_hyst_cmp_chk #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned HYST_W = DATA_W - 1
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              samp_vld,
  input logic [DATA_W-1:0] samp_data,
  input logic [DATA_W-1:0] thr,
  input logic [HYST_W-1:0] hyst,
  input logic              pol,
  input logic              level_o,
  input logic              irq_o,
  input logic              irq_clr
);
  p_set_above_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (samp_vld && samp_data > thr) |=> level_o);

  p_clear_below_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (samp_vld && ({1'b0, samp_data} + {2'b00, hyst}) < {1'b0, thr}) |=> !level_o);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !samp_vld |=> $stable(level_o));

  p_rise_irq_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!pol && !level_o && samp_vld && samp_data > thr) |=> irq_o);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_o && !irq_clr) |=> irq_o);

  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (level_o && {1'b0, hyst} >= thr) |=> level_o);
endmodule

bind env_hyst_cmp env_hyst_cmp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .samp_vld(samp_vld),
  .samp_data(samp_data), .thr(thr_q), .hyst(hyst_q), .pol(pol_q),
  .level_o(level_o), .irq_o(irq_o), .irq_clr(irq_clr)
);

// File: tb/env_hyst_cmp_test.sv
`timescale 1ns/1ps
module env_hyst_cmp_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        samp_vld, reg_wr, reg_sel, irq_clr;
  logic [15:0] samp_data, reg_wdata, reg_rdata;
  logic        level_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  logic [15:0] m_ctrl, m_thr;
  logic        m_lvl, m_irq;

  always #10 clk = ~clk;

  env_hyst_cmp uut (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp_data(samp_data),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .irq_clr(irq_clr), .reg_rdata(reg_rdata), .level_o(level_o),
    .irq_o(irq_o)
  );

  function automatic logic next_lvl(logic lvl, logic [15:0] s,
                                    logic [15:0] t, logic [14:0] h);
    int lo;
    lo = int'(t) - int'(h);
    if (lo < 0) lo = 0;
    if (int'(s) > int'(t)) return 1'b1;
    if (int'(s) < lo)      return 1'b0;
    return lvl;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic step(logic v, logic [15:0] d, logic w, logic s,
                      logic [15:0] wd, logic c, string tag);
    logic nl, hit;
    samp_vld = v; samp_data = d; reg_wr = w; reg_sel = s;
    reg_wdata = wd; irq_clr = c;
    @(posedge clk);
    nl  = v ? next_lvl(m_lvl, d, m_thr, m_ctrl[14:0]) : m_lvl;
    hit = m_ctrl[15] ? (m_lvl && !nl) : (!m_lvl && nl);
    m_irq = hit | (m_irq & ~c);
    m_lvl = nl;
    if (w) begin
      if (s) m_thr = wd; else m_ctrl = wd;
    end
    @(negedge clk);
    samp_vld = 0; reg_wr = 0; irq_clr = 0;
    chk({tag, " level"}, {15'b0, level_o}, {15'b0, m_lvl});
    chk({tag, " irq"},   {15'b0, irq_o},   {15'b0, m_irq});
  endtask

  task automatic rd(logic s, logic [15:0] exp, string tag);
    reg_sel = s;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(logic s, logic [15:0] v, string tag);
    step(0, 16'h0, 1, s, v, 0, tag);
  endtask

  task automatic smp(logic [15:0] v, string tag);
    step(1, v, 0, 0, 16'h0, 0, tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h1234abcd;
    void'($urandom(seed));
    rst_n = 0; samp_vld = 0; samp_data = 0; reg_wr = 0; reg_sel = 0;
    reg_wdata = 0; irq_clr = 0;
    m_ctrl = 0; m_thr = 0; m_lvl = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 level", {15'b0, level_o}, 16'h0);
    chk("R1 irq", {15'b0, irq_o}, 16'h0);
    rd(0, 16'h0000, "R1 ctrl read");
    rd(1, 16'h0000, "R1 thr read");

    // R2 / R3 register access
    wr(0, 16'hFFFF, "R2 write");
    rd(0, 16'hFFFF, "R2 ctrl all ones");
    wr(0, 16'h0064, "R2 write");
    rd(0, 16'h0064, "R2 ctrl readback");
    wr(1, 16'd1000, "R3 write");
    rd(1, 16'd1000, "R3 thr readback");

    // R6 equal to threshold holds low; R4 / R9 rising edge, pol 0
    smp(16'd1000, "R6 at threshold");
    smp(16'd1001, "R4 above / R9 rise");
    step(0, 16'h0, 0, 0, 16'h0, 1, "R10 clear");
    smp(16'd900, "R6 lower bound");
    smp(16'd899, "R5 below bound / R9 no fall irq");
    step(0, 16'd5000, 0, 0, 16'h0, 0, "R8 invalid ignored");

    // R9 falling edge, pol 1
    wr(0, 16'h8064, "R2 polarity set");
    smp(16'd1001, "R9 rise no irq pol1");
    smp(16'd899, "R9 fall irq pol1");
    step(0, 16'h0, 0, 0, 16'h0, 1, "R10 clear");
    smp(16'd1001, "R9 rise pol1");
    step(1, 16'd0, 0, 0, 16'h0, 1, "R10 edge beats clear");
    step(0, 16'h0, 0, 0, 16'h0, 1, "R10 clear");

    // R7 saturation
    wr(0, 16'h0064, "R7 cfg");
    wr(1, 16'd50, "R7 cfg");
    smp(16'd51, "R7 set");
    smp(16'd0, "R7 zero holds");
    step(0, 16'h0, 0, 0, 16'h0, 1, "R10 clear");

    // R11 config write no edge
    wr(1, 16'hFFFF, "R11 thr write keeps level");
    step(1, 16'h8000, 1, 1, 16'h0000, 0, "R11 same-edge write uses old");
    smp(16'h0001, "R11 new threshold applies");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic v, w, s, c;
      logic [15:0] d;
      v = ($urandom % 10) < 7;
      w = ($urandom % 20) == 0;
      s = $urandom % 2;
      c = ($urandom % 10) == 0;
      d = (($urandom % 2) == 0) ? 16'($urandom) :
          16'(int'(m_thr) + int'($urandom % 64) - 32);
      step(v, d, w, s, 16'(($urandom % 2) ? $urandom : ($urandom % 2048)),
           c, "R6 random model");
      if ((i % 97) == 0) begin
        rd(0, m_ctrl, "R2 random read");
        rd(1, m_thr, "R3 random read");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule